// File: doc/BRIEF.md
# Reference-Windowed Clock Ratio Checker

This block measures how many cycles of a fast clock (typically a PLL output) fit inside a fixed window of a slower, trusted reference clock. It then compares that count with the ratio the clock configuration is meant to produce. The configuration is given as an integer multiplier, a two-bit quarter-step fractional multiplier and a divider-select field. The window is set by a down-counter on the reference clock. A second down-counter runs on the measured clock. The measurement ends as soon as either counter expires.

The block works in three clock domains: a system clock for the start/done handshake and the arithmetic, the reference clock, and the measured clock. Start and stop events cross between the domains as two-flop synchronised toggles. The reference counter is armed first, and it then arms the measured counter. The measured count is captured only after the stop has settled in the measured-clock domain. A done toggle then carries the result back to the system domain.

The error is formed without division by cross-multiplying integers. The block reports the elapsed count, the signed scaled error, a within-tolerance flag and a timeout flag. The timeout flag shows that the measured counter ran out before the window closed.

Top module: `clkRatioChecker`

## Requirements
- R1: After reset, `busy`, `done`, `withinTol`, `timeout`, `measCount` and `errScaled` are all zero.
- R2: A `start` pulse sampled while `busy` is low raises `busy` on the next system clock. A `start` pulse while `busy` is high has no effect on the run in progress or on its results.
- R3: The window counter is loaded with `REF_LOAD` and decrements once per reference clock. The window ends when it reaches zero, after `REF_LOAD` reference cycles.
- R4: The measured counter is loaded with `MEAS_LOAD` only after the window counter has started, and it decrements once per measured clock. `measCount` reports `MEAS_LOAD` minus the value left in the counter. This is `REF_LOAD*f_meas/f_ref` within a synchroniser slack of 6 counts.
- R5: Both counters stop when either one expires first. An expired window stops the measured counter, and a wrapped measured counter stops the window counter.
- R6: If the measured counter reaches zero before the window ends, `timeout` is 1 and `measCount` equals `MEAS_LOAD`. Otherwise `timeout` is 0.
- R7: `errScaled` is a two's-complement value equal to `REF_LOAD*(4*intMult+fracMult) - 4*D*measCount`. D is 1 when `divSel` is 0 and `2*divSel` otherwise.
- R8: `withinTol` is 1 exactly when |`errScaled`| <= `tolerance`, with `tolerance` taken as unsigned.
- R9: `done` is a single-cycle pulse, and `busy` is low in that cycle. The results hold their values until the next `done`.
- R10: `intMult`, `fracMult`, `divSel` and `tolerance` are sampled when `start` is accepted. Later changes do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for control and arithmetic |
| refClk | input | 1 | Reference clock that times the window |
| measClk | input | 1 | Clock under measurement |
| rstN | input | 1 | Asynchronous active-low reset, all domains |
| start | input | 1 | Request a measurement (system domain) |
| intMult | input | IMULT_W | Integer multiplier |
| fracMult | input | 2 | Fractional multiplier in quarter steps |
| divSel | input | DIVSEL_W | Divider select (0 means divide by 1) |
| tolerance | input | TOL_W | Allowed magnitude of the scaled error |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| measCount | output | MEAS_W | Elapsed measured-clock count |
| errScaled | output | ERR_W | Signed scaled error |
| withinTol | output | 1 | Error magnitude within tolerance |
| timeout | output | 1 | Measured counter expired before the window |

## Verification
The bench builds the block with `REF_LOAD` = 64 and `MEAS_LOAD` = 2000. These values keep each window to a few thousand system cycles, so a ratio of 8, a divided ratio of 2.5 and a quarter-step ratio of 2.25 can all be measured in one short run. With a 40:1 clock pair the small `MEAS_LOAD` lets the measured counter run out before the window ends, which exercises the timeout path and the full-count result. The scaled error stays small enough that a deliberately wrong multiplier gives an error well outside the tolerance.

// File: rtl/crc_pkg.sv
`timescale 1ns/1ps
package crc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CAPT = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic launch;   // start accepted: sample config, arm reference domain
    logic capture;  // measured result arrived: latch count, form error
    logic publish;  // evaluate tolerance, present results
  } ctrlStrobe_t;

endpackage

// File: rtl/crcToggleSync.sv
`timescale 1ns/1ps
module crcToggleSync #(
  parameter int STAGES = 2
) (
  input  logic dstClk,
  input  logic rstN,
  input  logic tglIn,
  output logic pulseOut
);
  logic [STAGES-1:0] chain;
  logic              lastQ;

  always_ff @(posedge dstClk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      lastQ <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tglIn};
      lastQ <= chain[STAGES-1];
    end
  end

  assign pulseOut = chain[STAGES-1] ^ lastQ;
endmodule

// File: rtl/crcCtrl.sv
`timescale 1ns/1ps
module crcCtrl
  import crc_pkg::*;
(
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        start,
  input  logic        measDoneSeen,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  ctrlState_e state;

  always_comb begin
    strobe         = '0;
    strobe.launch  = (state == ST_IDLE) && start;
    strobe.capture = (state == ST_RUN) && measDoneSeen;
    strobe.publish = (state == ST_CAPT);
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (strobe.launch)  state <= ST_RUN;
        ST_RUN:  if (strobe.capture) state <= ST_CAPT;
        ST_CAPT: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R2: an accepted start makes the block busy on the next cycle
  p_start_busy_r2: assert property (@(posedge sysClk) disable iff (!rstN)
    start && !busy |=> busy);
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    done |=> !done);
  // R9: busy is low while done is shown
  p_done_idle_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/crcDatapath.sv
`timescale 1ns/1ps
module crcDatapath
  import crc_pkg::*;
#(
  parameter int          REF_LOAD  = 2048,
  parameter logic [63:0] MEAS_LOAD = 64'hF000_0000,
  parameter int          IMULT_W   = 7,
  parameter int          DIVSEL_W  = 6,
  parameter int          TOL_W     = 16,
  parameter int          SYNC_STG  = 2,
  parameter int          REF_W     = $clog2(REF_LOAD + 1),
  parameter int          MEAS_W    = $clog2(MEAS_LOAD + 1),
  parameter int          ERR_W     = 42
) (
  input  logic                sysClk,
  input  logic                refClk,
  input  logic                measClk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [IMULT_W-1:0]  intMult,
  input  logic [1:0]          fracMult,
  input  logic [DIVSEL_W-1:0] divSel,
  input  logic [TOL_W-1:0]    tolerance,
  output logic                measDoneSeen,
  output logic [MEAS_W-1:0]   measCount,
  output logic [ERR_W-1:0]    errScaled,
  output logic                withinTol,
  output logic                timeout
);
  localparam logic [MEAS_W-1:0] MEAS_INIT = MEAS_W'(MEAS_LOAD);
  localparam logic [REF_W-1:0]  REF_INIT  = REF_W'(REF_LOAD);
  localparam int                DIV_W     = DIVSEL_W + 1;

  // ---------------- system domain: configuration ----------------
  logic                startTgl;
  logic [IMULT_W-1:0]  cfgInt;
  logic [1:0]          cfgFrac;
  logic [DIVSEL_W-1:0] cfgDiv;
  logic [TOL_W-1:0]    cfgTol;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      startTgl <= 1'b0;
      cfgInt   <= '0;
      cfgFrac  <= '0;
      cfgDiv   <= '0;
      cfgTol   <= '0;
    end else if (strobe.launch) begin
      startTgl <= ~startTgl;
      cfgInt   <= intMult;
      cfgFrac  <= fracMult;
      cfgDiv   <= divSel;
      cfgTol   <= tolerance;
    end
  end

  // ---------------- reference domain: window counter ----------------
  logic             refStartPulse, refWrapPulse;
  logic             refRun, armTgl, stopTgl;
  logic [REF_W-1:0] refCnt;
  logic             wrapTgl;

  crcToggleSync #(.STAGES(SYNC_STG)) uRefStart (
    .dstClk(refClk), .rstN(rstN), .tglIn(startTgl), .pulseOut(refStartPulse));
  crcToggleSync #(.STAGES(SYNC_STG)) uRefWrap (
    .dstClk(refClk), .rstN(rstN), .tglIn(wrapTgl), .pulseOut(refWrapPulse));

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refRun  <= 1'b0;
      refCnt  <= '0;
      armTgl  <= 1'b0;
      stopTgl <= 1'b0;
    end else if (refStartPulse) begin
      refCnt <= REF_INIT;
      refRun <= 1'b1;
      armTgl <= ~armTgl;           // reference runs first, then arms the measured side
    end else if (refRun) begin
      if (refWrapPulse) begin
        refRun <= 1'b0;            // measured counter expired first
      end else begin
        refCnt <= refCnt - 1'b1;
        if (refCnt == REF_W'(1)) begin
          refRun  <= 1'b0;
          stopTgl <= ~stopTgl;
        end
      end
    end
  end

  // R3: the window counter steps down by one per reference cycle
  p_ref_step_r3: assert property (@(posedge refClk) disable iff (!rstN)
    refRun && !refWrapPulse && !refStartPulse |=> refCnt == $past(refCnt) - 1'b1);
  // R5: the window stops only on its own expiry or on a measured wrap
  p_ref_stop_r5: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(refRun) |-> (refCnt == '0) || $past(refWrapPulse));

  // ---------------- measured domain: measured counter ----------------
  logic              measArmPulse, measStopPulse;
  logic              measRun, captPend, wrapped, measTimeout, doneTgl;
  logic [MEAS_W-1:0] measCnt, measElapsed;

  crcToggleSync #(.STAGES(SYNC_STG)) uMeasArm (
    .dstClk(measClk), .rstN(rstN), .tglIn(armTgl), .pulseOut(measArmPulse));
  crcToggleSync #(.STAGES(SYNC_STG)) uMeasStop (
    .dstClk(measClk), .rstN(rstN), .tglIn(stopTgl), .pulseOut(measStopPulse));

  always_ff @(posedge measClk or negedge rstN) begin
    if (!rstN) begin
      measRun     <= 1'b0;
      measCnt     <= '0;
      captPend    <= 1'b0;
      wrapped     <= 1'b0;
      wrapTgl     <= 1'b0;
      measElapsed <= '0;
      measTimeout <= 1'b0;
      doneTgl     <= 1'b0;
    end else if (measArmPulse) begin
      measCnt  <= MEAS_INIT;
      measRun  <= 1'b1;
      wrapped  <= 1'b0;
      captPend <= 1'b0;
    end else if (measRun) begin
      if (measStopPulse) begin
        measRun  <= 1'b0;
        captPend <= 1'b1;
      end else begin
        measCnt <= measCnt - 1'b1;
        if (measCnt == MEAS_W'(1)) begin
          measRun  <= 1'b0;
          wrapped  <= 1'b1;
          wrapTgl  <= ~wrapTgl;
          captPend <= 1'b1;
        end
      end
    end else if (captPend) begin
      // counter is frozen for a full cycle before it is sampled
      measElapsed <= MEAS_INIT - measCnt;
      measTimeout <= wrapped;
      captPend    <= 1'b0;
      doneTgl     <= ~doneTgl;
    end
  end

  // R4: the measured counter steps down by one per measured cycle while running
  p_meas_step_r4: assert property (@(posedge measClk) disable iff (!rstN)
    measRun && !measStopPulse && !measArmPulse |=> measCnt == $past(measCnt) - 1'b1);

  crcToggleSync #(.STAGES(SYNC_STG)) uSysDone (
    .dstClk(sysClk), .rstN(rstN), .tglIn(doneTgl), .pulseOut(measDoneSeen));

  // ---------------- system domain: error arithmetic ----------------
  logic [DIV_W-1:0] divVal;
  logic [ERR_W-1:0] refProd, measProd, errNext, errReg, absErr;
  logic [MEAS_W-1:0] countReg;
  logic             timeoutReg, passReg;

  always_comb begin
    divVal   = (cfgDiv == '0) ? DIV_W'(1) : {cfgDiv, 1'b0};
    refProd  = ERR_W'(REF_LOAD) * ERR_W'({cfgInt, cfgFrac});
    measProd = ERR_W'(measElapsed) * ERR_W'({divVal, 2'b00});
    errNext  = refProd - measProd;
    absErr   = errReg[ERR_W-1] ? (~errReg + 1'b1) : errReg;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      countReg   <= '0;
      timeoutReg <= 1'b0;
      errReg     <= '0;
      passReg    <= 1'b0;
    end else begin
      if (strobe.capture) begin
        countReg   <= measElapsed;
        timeoutReg <= measTimeout;
        errReg     <= errNext;
      end
      if (strobe.publish) begin
        passReg <= (absErr <= ERR_W'(cfgTol));
      end
    end
  end

  assign measCount = countReg;
  assign errScaled = errReg;
  assign withinTol = passReg;
  assign timeout   = timeoutReg;

  // R4: a reported count never exceeds the load value
  p_count_range_r4: assert property (@(posedge sysClk) disable iff (!rstN)
    countReg <= MEAS_INIT);
  // R6: a timeout always comes with a full-length count
  p_timeout_full_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    timeoutReg |-> countReg == MEAS_INIT);
endmodule

// File: rtl/clkRatioChecker.sv
`timescale 1ns/1ps
module clkRatioChecker
  import crc_pkg::*;
#(
  parameter int          REF_LOAD  = 2048,
  parameter logic [63:0] MEAS_LOAD = 64'hF000_0000,
  parameter int          IMULT_W   = 7,
  parameter int          DIVSEL_W  = 6,
  parameter int          TOL_W     = 16,
  parameter int          SYNC_STG  = 2,
  localparam int         REF_W     = $clog2(REF_LOAD + 1),
  localparam int         MEAS_W    = $clog2(MEAS_LOAD + 1),
  localparam int         RPROD_W   = REF_W + IMULT_W + 2,
  localparam int         MPROD_W   = MEAS_W + DIVSEL_W + 3,
  localparam int         ERR_W     = ((RPROD_W > MPROD_W) ? RPROD_W : MPROD_W) + 1
) (
  input  logic                sysClk,
  input  logic                refClk,
  input  logic                measClk,
  input  logic                rstN,
  input  logic                start,
  input  logic [IMULT_W-1:0]  intMult,
  input  logic [1:0]          fracMult,
  input  logic [DIVSEL_W-1:0] divSel,
  input  logic [TOL_W-1:0]    tolerance,
  output logic                busy,
  output logic                done,
  output logic [MEAS_W-1:0]   measCount,
  output logic [ERR_W-1:0]    errScaled,
  output logic                withinTol,
  output logic                timeout
);
  ctrlStrobe_t strobe;
  logic        measDoneSeen;

  crcCtrl uCtrl (
    .sysClk(sysClk), .rstN(rstN), .start(start), .measDoneSeen(measDoneSeen),
    .strobe(strobe), .busy(busy), .done(done));

  crcDatapath #(
    .REF_LOAD(REF_LOAD), .MEAS_LOAD(MEAS_LOAD), .IMULT_W(IMULT_W),
    .DIVSEL_W(DIVSEL_W), .TOL_W(TOL_W), .SYNC_STG(SYNC_STG),
    .REF_W(REF_W), .MEAS_W(MEAS_W), .ERR_W(ERR_W)
  ) uDp (
    .sysClk(sysClk), .refClk(refClk), .measClk(measClk), .rstN(rstN),
    .strobe(strobe), .intMult(intMult), .fracMult(fracMult), .divSel(divSel),
    .tolerance(tolerance), .measDoneSeen(measDoneSeen), .measCount(measCount),
    .errScaled(errScaled), .withinTol(withinTol), .timeout(timeout));
endmodule

// File: tb/tb_clkRatioChecker.sv
`timescale 1ns/1ps
module tb_clkRatioChecker;
  localparam int REF_LOAD  = 64;
  localparam int MEAS_LOAD = 2000;
  localparam int MEAS_W    = $clog2(MEAS_LOAD + 1);
  localparam int ERR_W     = 21;   // max(7+7+2, 11+6+3) + 1
  localparam int SLACK     = 6;

  logic sysClk = 0, refClk = 0, measClk = 0, rstN = 0, start = 0;
  logic [6:0]  intMult = 0;
  logic [1:0]  fracMult = 0;
  logic [5:0]  divSel = 0;
  logic [15:0] tolerance = 0;
  logic busy, done, withinTol, timeout;
  logic [MEAS_W-1:0] measCount;
  logic [ERR_W-1:0]  errScaled;

  real refHalf = 40.0, measHalf = 5.0;
  int  checks = 0, failures = 0, cycles = 0;
  bit  modelBusy = 0, acceptQ = 0, finished = 0;

  always #5 sysClk = ~sysClk;
  initial forever #(refHalf)  refClk  = ~refClk;
  initial forever #(measHalf) measClk = ~measClk;

  clkRatioChecker #(.REF_LOAD(REF_LOAD), .MEAS_LOAD(64'(MEAS_LOAD))) dut (
    .sysClk(sysClk), .refClk(refClk), .measClk(measClk), .rstN(rstN),
    .start(start), .intMult(intMult), .fracMult(fracMult), .divSel(divSel),
    .tolerance(tolerance), .busy(busy), .done(done), .measCount(measCount),
    .errScaled(errScaled), .withinTol(withinTol), .timeout(timeout));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural busy model, compared on every system clock (R2, R9)
  always @(posedge sysClk) if (rstN) acceptQ <= start && !modelBusy;
  always @(negedge sysClk) begin
    if (rstN && !finished) begin
      if (acceptQ) modelBusy = 1;
      if (done) begin
        check(modelBusy, "R9 done without run", 1, 0);
        check(busy == 0, "R9 busy during done", busy, 0);
        modelBusy = 0;
      end else begin
        check(busy == modelBusy, "R2 busy tracking", busy, modelBusy);
      end
    end
  end

  // Watchdog
  always @(posedge sysClk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulseStart();
    @(posedge sysClk); #1 start = 1;
    @(posedge sysClk); #1 start = 0;
  endtask

  task automatic runCase(input real refPer, input real measPer, input int im,
                         input int fm, input int ds, input int tol,
                         input bit expTo, input bit disturb, input string tag);
    longint nomCnt, expErr, absErr, divv, held;
    int waitCnt;
    refHalf = refPer / 2.0; measHalf = measPer / 2.0;
    repeat (20) @(posedge sysClk);
    #1 intMult = 7'(im); fracMult = 2'(fm); divSel = 6'(ds); tolerance = 16'(tol);
    pulseStart();
    if (disturb) begin
      repeat (30) @(posedge sysClk);
      #1 intMult = 7'd99; fracMult = 2'd3; divSel = 6'd9; tolerance = 16'd0;
      pulseStart();   // R2, R10: ignored while busy
    end
    waitCnt = 0;
    @(negedge sysClk);
    while (!done && waitCnt < 20000) begin @(negedge sysClk); waitCnt++; end
    check(done == 1, {tag, " R9 done seen"}, done, 1);
    nomCnt = longint'(REF_LOAD * refPer / measPer);
    if (expTo) begin
      check(measCount == MEAS_LOAD, {tag, " R6 full count"}, measCount, MEAS_LOAD);
      check(timeout == 1, {tag, " R6 timeout"}, timeout, 1);
    end else begin
      check(longint'(measCount) >= nomCnt - SLACK && longint'(measCount) <= nomCnt + SLACK,
            {tag, " R4 R3 R5 count window"}, measCount, nomCnt);
      check(timeout == 0, {tag, " R6 no timeout"}, timeout, 0);
    end
    divv   = (ds == 0) ? 1 : 2 * ds;
    expErr = longint'(REF_LOAD) * (4 * im + fm) - 4 * divv * longint'(measCount);
    check(longint'($signed(errScaled)) == expErr, {tag, " R7 R10 error"},
          longint'($signed(errScaled)), expErr);
    absErr = (expErr < 0) ? -expErr : expErr;
    check(withinTol == (absErr <= tol), {tag, " R8 tolerance"}, withinTol, absErr <= tol);
    held = longint'(measCount);
    repeat (3) @(negedge sysClk);
    check(done == 0 && longint'(measCount) == held, {tag, " R9 single pulse, hold"},
          measCount, held);
  endtask

  initial begin
    repeat (4) @(posedge sysClk);
    #1 rstN = 1;
    @(negedge sysClk);
    check(busy == 0 && done == 0, "R1 reset control", {busy, done}, 0);
    check(measCount == 0 && errScaled == 0, "R1 reset data", measCount, 0);
    check(withinTol == 0 && timeout == 0, "R1 reset flags", {withinTol, timeout}, 0);
    // ratio 8, exact match
    runCase(80.0, 10.0, 8, 0, 0, 40, 0, 0, "A");
    check(withinTol == 1, "A R8 pass expected", withinTol, 1);
    // ratio 2.5 via divider select 1 (divide by 2)
    runCase(25.0, 10.0, 5, 0, 1, 64, 0, 0, "B");
    check(withinTol == 1, "B R7 divider pass", withinTol, 1);
    // ratio 2.25 via quarter-step fraction
    runCase(45.0, 20.0, 2, 1, 0, 40, 0, 0, "C");
    check(withinTol == 1, "C R7 fraction pass", withinTol, 1);
    // wrong multiplier: large positive error, out of tolerance
    runCase(80.0, 10.0, 10, 0, 0, 40, 0, 0, "D");
    check(withinTol == 0 && $signed(errScaled) > 0, "D R8 mismatch fails", withinTol, 0);
    // measured counter runs out first
    runCase(200.0, 5.0, 40, 0, 0, 100, 1, 0, "E");
    // start and config changes while busy are ignored
    runCase(80.0, 10.0, 8, 0, 0, 40, 0, 1, "F");
    check(withinTol == 1, "F R10 R2 launch config kept", withinTol, 1);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule